// File: doc/BRIEF.md
# Tiled Address Channel Swizzler

This block works out how a tiled surface's byte addresses must be scrambled so that they agree with the channel interleave applied by a dual-channel memory system. It then applies that scrambling to a stream of addresses. From static configuration pins it derives an internal swizzle code for X tiling and one for Y tiling. The pins are a platform class, a memory configuration word and a rank-size match flag. The requested tiling mode picks one of those two codes.

The block reports the selected code to software in a reduced form. Modes that involve address bit 17 are shown as their bit-17-free counterparts. An unusable configuration drops the surface back to untiled. The address stream passes through one register stage. In that stage, address bit 6 is XORed with the source bits that the internal code names, and every other bit passes through untouched.

The address stream uses valid/ready handshakes. An input beat is taken when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output beat holds its value and no new beat is taken. The configuration and tiling pins are plain levels, sampled together with the address when a beat is taken.

Top module: `tswz_top`

## Requirements
- R1: Platform select `plat_sel` 0 (flat) gives internal code 0 for both X and Y; `plat_sel` 3 (fixed interleave) gives 2 for X and 1 for Y. Codes: 0 none, 1 bit 9, 2 bits 9+10, 3 bits 9+11, 4 bits 9+10+11, 5 unknown, 6 bits 9+17, 7 bits 9+10+17.
- R2: With `plat_sel` 1 (configuration word), the addressing-mode field `cfg_word[1:0]` behaves as follows. Value 0 (single channel) and value 1 (asymmetric dual) give code 0 for X and Y. Value 3 (reserved) gives code 5 for X and Y.
- R3: With `plat_sel` 1 and mode field 2 (interleaved), the outcome depends on two bits. If `cfg_word[2]` (channel XOR off) is 1, the codes are X 2 and Y 1. Otherwise `cfg_word[3]` picks the upper bit: 0 gives X 4 and Y 3, and 1 gives X 7 and Y 6.
- R4: With `plat_sel` 1, a configuration word of all ones gives code 5 for X and Y.
- R5: With `plat_sel` 2 (rank compare), `rank_match` 0 gives code 0 for X and Y, and `rank_match` 1 gives X 2 and Y 1.
- R6: `tile_mode` encoding is 0 none, 1 X, 2 Y, 3 treated as none. `raw_code` is the internal code of the requested tiling, or 0 when untiled. `swz_code` equals `raw_code`, except that 6 reports as 1, 7 reports as 2, and untiled reports as 0.
- R7: When `raw_code` is 5, `tile_eff` is 0, `swz_code` is 0 and the address is not changed. Otherwise `tile_eff` is the requested mode, with 3 shown as 0.
- R8: For an accepted beat, output bit 6 is input bit 6 XOR every source bit named by `raw_code` at acceptance. All other bits are copied unchanged.
- R9: A beat accepted at one clock edge appears on `out_addr` with `out_valid` high from the next edge. After reset `out_valid` is 0.
- R10: While `out_valid` is high and `out_ready` is low, `out_addr` and `out_valid` hold and `in_ready` is 0. `in_ready` is 1 when `out_valid` is 0 or `out_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| plat_sel | input | 2 | Platform class: 0 flat, 1 config word, 2 rank compare, 3 fixed interleave |
| cfg_word | input | CFG_W | Memory configuration word |
| rank_match | input | 1 | Per-channel rank sizes are equal |
| tile_mode | input | 2 | Requested tiling: 0 none, 1 X, 2 Y, 3 none |
| raw_code | output | 3 | Internal swizzle code of the requested tiling |
| swz_code | output | 3 | Swizzle code reported to software |
| tile_eff | output | 2 | Tiling mode actually in force |
| in_valid | input | 1 | Input address beat valid |
| in_ready | output | 1 | Input beat can be taken |
| in_addr | input | ADDR_W | Input byte address |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the output beat |
| out_addr | output | ADDR_W | Swizzled byte address |

## Verification
The bench builds the block with `ADDR_W` = 20 and `CFG_W` = 12. With a 12-bit word, the all-ones configuration is cheap to drive. With 20 address bits, bit 17 falls within the address, and the two bits above it can be checked for unchanged pass-through. Each internal code is reached through its configuration path, with addresses whose bits 9, 10, 11 and 17 are set in patterns that flip or keep bit 6. A stalled output with a second beat waiting exercises the hold rule.

// File: rtl/tswz_pkg.sv
package tswz_pkg;

  typedef enum logic [1:0] {
    TILE_NONE = 2'd0,
    TILE_X    = 2'd1,
    TILE_Y    = 2'd2,
    TILE_RSVD = 2'd3
  } tile_e;

  typedef enum logic [2:0] {
    SWZ_NONE      = 3'd0,
    SWZ_B9        = 3'd1,
    SWZ_B9_10     = 3'd2,
    SWZ_B9_11     = 3'd3,
    SWZ_B9_10_11  = 3'd4,
    SWZ_UNKNOWN   = 3'd5,
    SWZ_B9_17     = 3'd6,
    SWZ_B9_10_17  = 3'd7
  } swz_e;

  typedef enum logic [1:0] {
    PLAT_FLAT    = 2'd0,
    PLAT_CFGWORD = 2'd1,
    PLAT_RANK    = 2'd2,
    PLAT_FIXED   = 2'd3
  } plat_e;

  typedef enum logic [1:0] {
    AM_SINGLE = 2'd0,
    AM_ASYM   = 2'd1,
    AM_INTLV  = 2'd2,
    AM_RSVD   = 2'd3
  } amode_e;

  // Number of candidate source bits and their address positions
  localparam int unsigned NSRC = 4;
  localparam int unsigned DST_BIT = 6;

  function automatic int unsigned src_pos(int unsigned k);
    case (k)
      0: return 9;
      1: return 10;
      2: return 11;
      default: return 17;
    endcase
  endfunction

  // Selected source bits {b17, b11, b10, b9} for an internal code
  function automatic logic [NSRC-1:0] src_sel(logic [2:0] code);
    case (code)
      3'd1: return 4'b0001;
      3'd2: return 4'b0011;
      3'd3: return 4'b0101;
      3'd4: return 4'b0111;
      3'd6: return 4'b1001;
      3'd7: return 4'b1011;
      default: return 4'b0000;
    endcase
  endfunction

endpackage

// File: rtl/tswz_mode_decode.sv
module tswz_mode_decode
  import tswz_pkg::*;
#(
  parameter int unsigned CFG_W       = 32,
  parameter int unsigned XOR_OFF_BIT = 2,
  parameter int unsigned HI_SEL_BIT  = 3
) (
  input  logic [1:0]       plat_sel,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             rank_match,
  output logic [2:0]       code_x,
  output logic [2:0]       code_y
);

  logic [1:0] am;
  logic       xor_off;
  logic       hi_sel;
  logic       word_bad;

  assign am       = cfg_word[1:0];
  assign xor_off  = cfg_word[XOR_OFF_BIT];
  assign hi_sel   = cfg_word[HI_SEL_BIT];
  assign word_bad = &cfg_word;

  always_comb begin
    code_x = SWZ_NONE;
    code_y = SWZ_NONE;
    case (plat_sel)
      PLAT_FLAT: begin
        code_x = SWZ_NONE;
        code_y = SWZ_NONE;
      end
      PLAT_CFGWORD: begin
        code_x = SWZ_UNKNOWN;
        code_y = SWZ_UNKNOWN;
        case (am)
          AM_SINGLE, AM_ASYM: begin
            code_x = SWZ_NONE;
            code_y = SWZ_NONE;
          end
          AM_INTLV: begin
            if (xor_off) begin
              code_x = SWZ_B9_10;
              code_y = SWZ_B9;
            end else if (!hi_sel) begin
              code_x = SWZ_B9_10_11;
              code_y = SWZ_B9_11;
            end else begin
              code_x = SWZ_B9_10_17;
              code_y = SWZ_B9_17;
            end
          end
          default: begin
            code_x = SWZ_UNKNOWN;
            code_y = SWZ_UNKNOWN;
          end
        endcase
        if (word_bad) begin
          code_x = SWZ_UNKNOWN;
          code_y = SWZ_UNKNOWN;
        end
      end
      PLAT_RANK: begin
        if (rank_match) begin
          code_x = SWZ_B9_10;
          code_y = SWZ_B9;
        end
      end
      default: begin
        code_x = SWZ_B9_10;
        code_y = SWZ_B9;
      end
    endcase
  end

endmodule

// File: rtl/tswz_report.sv
module tswz_report
  import tswz_pkg::*;
(
  input  logic [1:0] tile_mode,
  input  logic [2:0] code_x,
  input  logic [2:0] code_y,
  output logic [2:0] raw_code,
  output logic [2:0] swz_code,
  output logic [1:0] tile_eff
);

  always_comb begin
    case (tile_mode)
      TILE_X:  raw_code = code_x;
      TILE_Y:  raw_code = code_y;
      default: raw_code = SWZ_NONE;
    endcase
  end

  always_comb begin
    tile_eff = (tile_mode == TILE_RSVD) ? TILE_NONE : tile_mode;
    swz_code = raw_code;
    case (raw_code)
      SWZ_B9_17:    swz_code = SWZ_B9;
      SWZ_B9_10_17: swz_code = SWZ_B9_10;
      SWZ_UNKNOWN: begin
        swz_code = SWZ_NONE;
        tile_eff = TILE_NONE;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/tswz_xlate_stage.sv
module tswz_xlate_stage
  import tswz_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        code,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr
);

  logic [NSRC-1:0]   sel;
  logic [NSRC-1:0]   taps;
  logic [ADDR_W-1:0] next_addr;
  logic              take;

  assign sel = src_sel(code);

  for (genvar k = 0; k < NSRC; k++) begin : g_tap
    assign taps[k] = sel[k] & in_addr[src_pos(k)];
  end

  for (genvar i = 0; i < ADDR_W; i++) begin : g_lane
    if (i == DST_BIT) begin : g_dst
      assign next_addr[i] = in_addr[i] ^ (^taps);
    end else begin : g_pass
      assign next_addr[i] = in_addr[i];
    end
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_addr  <= next_addr;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tswz_top.sv
module tswz_top
  import tswz_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned CFG_W       = 32,
  parameter int unsigned XOR_OFF_BIT = 2,
  parameter int unsigned HI_SEL_BIT  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        plat_sel,
  input  logic [CFG_W-1:0]  cfg_word,
  input  logic              rank_match,
  input  logic [1:0]        tile_mode,
  output logic [2:0]        raw_code,
  output logic [2:0]        swz_code,
  output logic [1:0]        tile_eff,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr
);

  localparam int unsigned MIN_ADDR_W = 18;
  localparam int unsigned MIN_CFG_W  = (XOR_OFF_BIT > HI_SEL_BIT ? XOR_OFF_BIT : HI_SEL_BIT) + 1;

  initial begin
    if (ADDR_W < MIN_ADDR_W) $error("ADDR_W must cover bit 17");
    if (CFG_W < MIN_CFG_W || CFG_W < 2) $error("CFG_W too narrow for its fields");
  end

  logic [2:0] code_x;
  logic [2:0] code_y;

  tswz_mode_decode #(
    .CFG_W      (CFG_W),
    .XOR_OFF_BIT(XOR_OFF_BIT),
    .HI_SEL_BIT (HI_SEL_BIT)
  ) dec_i (
    .plat_sel  (plat_sel),
    .cfg_word  (cfg_word),
    .rank_match(rank_match),
    .code_x    (code_x),
    .code_y    (code_y)
  );

  tswz_report rep_i (
    .tile_mode(tile_mode),
    .code_x   (code_x),
    .code_y   (code_y),
    .raw_code (raw_code),
    .swz_code (swz_code),
    .tile_eff (tile_eff)
  );

  tswz_xlate_stage #(
    .ADDR_W(ADDR_W)
  ) xl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .code     (raw_code),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_addr  (in_addr),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_addr (out_addr)
  );

endmodule

// File: rtl/tswz_checker.sv
module tswz_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CFG_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        plat_sel,
  input logic [CFG_W-1:0]  cfg_word,
  input logic [1:0]        tile_mode,
  input logic [2:0]        raw_code,
  input logic [2:0]        swz_code,
  input logic [1:0]        tile_eff,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_addr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr
);

  localparam logic [ADDR_W-1:0] KEEP = ~(ADDR_W'(1) << 6);

  // R6: reported code never shows unknown or upper-bit modes
  p_report_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    swz_code <= 3'd4);

  // R6: untiled request reports code 0
  p_untiled_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tile_mode == 2'd0 || tile_mode == 2'd3) |-> (swz_code == 3'd0 && raw_code == 3'd0));

  // R4: all-ones configuration word drops tiling
  p_all_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (plat_sel == 2'd1 && (&cfg_word)) |-> (tile_eff == 2'd0 && swz_code == 3'd0));

  // R8: only bit 6 may differ from the accepted address
  p_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && ((out_addr ^ $past(in_addr)) & KEEP) == '0));

  // R7: no effective tiling leaves bit 6 alone
  p_unk_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && tile_eff == 2'd0) |=> (out_addr[6] == $past(in_addr[6])));

  // R10: stalled output holds
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

  // R10: no acceptance while stalled
  p_stall_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9: output empties when drained with nothing taken
  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

endmodule

bind tswz_top tswz_checker #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .plat_sel(plat_sel), .cfg_word(cfg_word),
  .tile_mode(tile_mode), .raw_code(raw_code), .swz_code(swz_code),
  .tile_eff(tile_eff), .in_valid(in_valid), .in_ready(in_ready),
  .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
  .out_addr(out_addr)
);

// File: tb/tswz_top_tb_top.sv
`timescale 1ns/1ps
module tswz_top_tb_top;

  localparam int AW = 20;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    plat_sel = 2'd0;
  logic [CW-1:0] cfg_word = '0;
  logic          rank_match = 1'b0;
  logic [1:0]    tile_mode = 2'd0;
  logic [2:0]    raw_code, swz_code;
  logic [1:0]    tile_eff;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [AW-1:0] in_addr = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [AW-1:0] out_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  tswz_top #(.ADDR_W(AW), .CFG_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .plat_sel(plat_sel), .cfg_word(cfg_word),
    .rank_match(rank_match), .tile_mode(tile_mode), .raw_code(raw_code),
    .swz_code(swz_code), .tile_eff(tile_eff), .in_valid(in_valid),
    .in_ready(in_ready), .in_addr(in_addr), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] model_addr(logic [AW-1:0] a, int code);
    logic f;
    f = 1'b0;
    if (code inside {1, 2, 3, 4, 6, 7}) f ^= a[9];
    if (code inside {2, 4, 7})          f ^= a[10];
    if (code inside {3, 4})             f ^= a[11];
    if (code inside {6, 7})             f ^= a[17];
    model_addr = a;
    model_addr[6] = a[6] ^ f;
  endfunction

  function automatic int model_report(int raw);
    if (raw == 6) return 1;
    if (raw == 7) return 2;
    if (raw == 5) return 0;
    return raw;
  endfunction

  task automatic setup(input logic [1:0] p, input logic [CW-1:0] w,
                       input logic m, input logic [1:0] t);
    @(negedge clk);
    plat_sel = p; cfg_word = w; rank_match = m; tile_mode = t;
    #1;
  endtask

  // drive both tilings and compare raw / reported codes
  task automatic codes(input string tag, input logic [1:0] p, input logic [CW-1:0] w,
                       input logic m, input int ex, input int ey);
    setup(p, w, m, 2'd1);
    check({tag, " raw X"}, raw_code, ex);
    check({tag, " rep X"}, swz_code, model_report(ex));
    check({tag, " eff X"}, tile_eff, (ex == 5) ? 0 : 1);
    setup(p, w, m, 2'd2);
    check({tag, " raw Y"}, raw_code, ey);
    check({tag, " rep Y"}, swz_code, model_report(ey));
    check({tag, " eff Y"}, tile_eff, (ey == 5) ? 0 : 2);
  endtask

  task automatic send(input string tag, input logic [AW-1:0] a, input int code);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R9 valid"}, out_valid, 1);
    check({tag, " R8 addr"}, out_addr, model_addr(a, code));
  endtask

  task automatic t_reset;
    check("R9 reset out_valid", out_valid, 0);
    check("R10 reset in_ready", in_ready, 1);
  endtask

  task automatic t_platforms;
    codes("R1 flat", 2'd0, 12'h0, 1'b1, 0, 0);
    codes("R1 fixed", 2'd3, 12'h0, 1'b0, 2, 1);
    codes("R5 rank differ", 2'd2, 12'h0, 1'b0, 0, 0);
    codes("R5 rank match", 2'd2, 12'h0, 1'b1, 2, 1);
  endtask

  task automatic t_cfgword;
    codes("R2 single", 2'd1, 12'h00C, 1'b0, 0, 0);
    codes("R2 asym", 2'd1, 12'h00D, 1'b0, 0, 0);
    codes("R2 reserved", 2'd1, 12'h003, 1'b0, 5, 5);
    codes("R3 xor off", 2'd1, 12'h00E, 1'b0, 2, 1);
    codes("R3 bit11", 2'd1, 12'h002, 1'b0, 4, 3);
    codes("R3 bit17", 2'd1, 12'h00A, 1'b0, 7, 6);
    codes("R4 all ones", 2'd1, 12'hFFF, 1'b0, 5, 5);
  endtask

  task automatic t_untiled;
    setup(2'd1, 12'h00A, 1'b0, 2'd0);
    check("R6 none raw", raw_code, 0);
    check("R6 none rep", swz_code, 0);
    setup(2'd3, 12'h0, 1'b0, 2'd3);
    check("R6 rsvd tile raw", raw_code, 0);
    check("R7 rsvd tile eff", tile_eff, 0);
  endtask

  task automatic t_addresses;
    setup(2'd3, 12'h0, 1'b0, 2'd1);   // code 2
    send("c2 b9", 20'h00200, 2);
    send("c2 b9b10", 20'h00600, 2);
    send("c2 b6 b10", 20'h00440, 2);
    setup(2'd1, 12'h002, 1'b0, 2'd1); // code 4
    send("c4 b11", 20'h00800, 4);
    send("c4 all", 20'hFFFBF, 4);
    setup(2'd1, 12'h00A, 1'b0, 2'd1); // code 7
    send("c7 b17", 20'h20000, 7);
    send("c7 b17 b10", 20'hE0400, 7);
    setup(2'd1, 12'h00A, 1'b0, 2'd2); // code 6
    send("c6 b17 b10", 20'h20400, 6);
    setup(2'd1, 12'h002, 1'b0, 2'd2); // code 3
    send("c3 b11", 20'h00840, 3);
    setup(2'd1, 12'hFFF, 1'b0, 2'd1); // unknown
    send("R7 unknown", 20'h20E00, 0);
    setup(2'd3, 12'h0, 1'b0, 2'd0);   // untiled
    send("R7 untiled", 20'h20E40, 0);
  endtask

  task automatic t_backpressure;
    logic [AW-1:0] a0, a1;
    a0 = 20'h00240; a1 = 20'h00A00;
    setup(2'd3, 12'h0, 1'b0, 2'd2);   // code 1
    out_ready = 1'b0;
    in_valid = 1'b1; in_addr = a0;
    @(negedge clk);
    in_addr = a1;
    #1;
    check("R10 stall ready", in_ready, 0);
    check("R9 first out", out_addr, model_addr(a0, 1));
    @(negedge clk);
    check("R10 hold valid", out_valid, 1);
    check("R10 hold addr", out_addr, model_addr(a0, 1));
    out_ready = 1'b1;
    #1;
    check("R10 drain ready", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 second out", out_addr, model_addr(a1, 1));
    @(negedge clk);
    check("R9 drained", out_valid, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_platforms();
    t_cfgword();
    t_untiled();
    t_addresses();
    t_backpressure();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule